// File: doc/BRIEF.md
# Power-Up Configuration Sequencer for a Three-Wire Serial Slave

This block is the host-side master that brings a four-channel receiver front end into a working state after power-up. It runs from a system clock and produces the three serial lines the slave expects: a serial clock, a data line and a load strobe. Once started, it sends a fixed list of eight 32-bit configuration words and then reports that it has finished.

Each word goes out most significant bit first, and the slave takes each bit on a rising edge of the serial clock. Once the 32nd bit has been taken, the strobe pulses high one time, and this moves the word into the slave register that its two low bits select. The minimum times for data setup and hold, clock high and low, strobe setup and strobe width are given in nanoseconds. At elaboration they are rounded up to whole system-clock cycles.

A single-cycle `start` pulse begins the sequence. `busy` stays high for as long as the sequence runs, and `done` pulses for one cycle when it ends.

Top module: `cfg_seq_master`

## Requirements
- R1: While reset is asserted and immediately after it is released, `ser_clk`, `ser_data`, `ser_le`, `busy` and `done` are all 0.
- R2: One run sends exactly eight words, in this order: 0x00000003, 0x00020406, 0x20001499, 0x40001499, 0x60001499, 0x80001499, 0xA0000019, 0x80007CA0.
- R3: Each word is sent as 32 bits, bit 31 first and bit 0 last. One bit is presented per rising edge of `ser_clk`, and there are exactly 32 rising edges between consecutive strobe pulses.
- R4: `ser_data` never changes in a cycle in which `ser_clk` is high, and this includes the cycle in which `ser_clk` rises. Data is therefore set up for a full low phase before each rising edge and is held for a full high phase after it.
- R5: Every high phase of `ser_clk` lasts at least ceil(max(T_CLK_HI_NS, T_HOLD_NS)/SYS_PERIOD_NS) cycles, and every low phase lasts at least ceil(max(T_CLK_LO_NS, T_SETUP_NS)/SYS_PERIOD_NS) cycles. With the defaults both values are 3.
- R6: `ser_le` stays low while bits are being shifted. It rises only after `ser_clk` has fallen following bit 0, is never high at the same time as `ser_clk`, and stays high for at least ceil(T_LE_W_NS/SYS_PERIOD_NS) cycles, which is 2 with the defaults.
- R7: After a strobe falls, at least ceil(T_LE_SETUP_NS/SYS_PERIOD_NS) cycles pass before the next rising edge of `ser_clk`. This is 2 with the defaults.
- R8: A `start` pulse that arrives while `busy` is high is ignored. It does not add words, change the words already sent or extend the run.
- R9: `done` is high for exactly one cycle. That cycle is the one in which `busy` first reads 0, it comes after the eighth strobe has fallen, and no strobe follows it.
- R10: `busy` is 1 in the cycle after `start` is sampled while the block is idle.
- R11: After `done`, a new `start` pulse runs the complete eight-word sequence again from the first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence when the block is idle |
| ser_clk | output | 1 | Serial clock to the slave |
| ser_data | output | 1 | Serial data to the slave, MSB first |
| ser_le | output | 1 | Load strobe; a high pulse commits the shifted word |
| busy | output | 1 | High while the sequence runs |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The bench runs the sequence twice. In the first run a second `start` is injected in the middle of the run. In the second run no extra pulse is given, so any difference between the two runs in the captured word list, or any extra words, exposes a start that was not ignored. For every word it reassembles, the bench records the shortest high phase and shortest low phase of `ser_clk`, whether data moved while the clock was high, the strobe width and the gap between a strobe and the next clock. A wrong phase count, swapped bit order or a misplaced strobe therefore shows up in the word where it happens, not only in the final total. Checks on the idle state after reset and after `done` confirm that no strobe or clock edge leaks out between runs.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

   localparam int WORD_W    = 32;
   localparam int NUM_WORDS = 8;
   localparam int STEP_W    = $clog2(NUM_WORDS);
   localparam int BIT_W     = $clog2(WORD_W);

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_LOW,
      SQ_HIGH,
      SQ_TAIL,
      SQ_LATCH,
      SQ_GAP
   } sq_state_t;

   // round a nanosecond minimum up to whole cycles, never below one
   function automatic int ns_to_cyc(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cfgseq_rom.sv
module cfgseq_rom
   import cfgseq_pkg::*;
(
   input  logic [STEP_W-1:0] step,
   output logic [WORD_W-1:0] word
);

   localparam logic [WORD_W-1:0] SEQ_TABLE [NUM_WORDS] = '{
      32'h0000_0003,
      32'h0002_0406,
      32'h2000_1499,
      32'h4000_1499,
      32'h6000_1499,
      32'h8000_1499,
      32'hA000_0019,
      32'h8000_7CA0
   };

   assign word = SEQ_TABLE[step];

endmodule

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/cfg_seq_master.sv
module cfg_seq_master
   import cfgseq_pkg::*;
#(
   parameter int SYS_PERIOD_NS   = 10,
   parameter int T_CLK_HI_NS     = 25,
   parameter int T_CLK_LO_NS     = 25,
   parameter int T_SETUP_NS      = 10,
   parameter int T_HOLD_NS       = 10,
   parameter int T_CLK_TO_LE_NS  = 10,
   parameter int T_LE_W_NS       = 20,
   parameter int T_LE_SETUP_NS   = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ser_clk,
   output logic ser_data,
   output logic ser_le,
   output logic busy,
   output logic done
);

   localparam int LO_CYC   = max_of(ns_to_cyc(T_CLK_LO_NS, SYS_PERIOD_NS),
                                    ns_to_cyc(T_SETUP_NS, SYS_PERIOD_NS));
   localparam int HI_CYC   = max_of(ns_to_cyc(T_CLK_HI_NS, SYS_PERIOD_NS),
                                    ns_to_cyc(T_HOLD_NS, SYS_PERIOD_NS));
   localparam int TAIL_CYC = ns_to_cyc(T_CLK_TO_LE_NS, SYS_PERIOD_NS);
   localparam int LEW_CYC  = ns_to_cyc(T_LE_W_NS, SYS_PERIOD_NS);
   localparam int GAP_CYC  = ns_to_cyc(T_LE_SETUP_NS, SYS_PERIOD_NS);
   localparam int MAX_CYC  = max_of(max_of(LO_CYC, HI_CYC),
                                    max_of(TAIL_CYC, max_of(LEW_CYC, GAP_CYC)));
   localparam int CNT_W    = $clog2(MAX_CYC) + 1;

   localparam logic [CNT_W-1:0]  LO_LD   = CNT_W'(LO_CYC - 1);
   localparam logic [CNT_W-1:0]  HI_LD   = CNT_W'(HI_CYC - 1);
   localparam logic [CNT_W-1:0]  TAIL_LD = CNT_W'(TAIL_CYC - 1);
   localparam logic [CNT_W-1:0]  LEW_LD  = CNT_W'(LEW_CYC - 1);
   localparam logic [CNT_W-1:0]  GAP_LD  = CNT_W'(GAP_CYC - 1);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_WORDS - 1);
   localparam logic [BIT_W-1:0]  TOP_BIT   = BIT_W'(WORD_W - 1);

   generate
      if (SYS_PERIOD_NS < 1) begin : g_bad_period
         $error("cfg_seq_master: SYS_PERIOD_NS must be positive");
      end
      if ((1 << STEP_W) != NUM_WORDS) begin : g_bad_steps
         $error("cfg_seq_master: word count must be a power of two");
      end
   endgenerate

   sq_state_t         state;
   logic [STEP_W-1:0] step;
   logic [BIT_W-1:0]  bit_idx;
   logic [WORD_W-1:0] cur_word;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_zero;

   cfgseq_rom u_rom (
      .step (step),
      .word (cur_word)
   );

   cfgseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   // phase length loaded on every transition
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = LO_LD;
      unique case (state)
         SQ_IDLE:  begin tmr_load = start;    tmr_val = LO_LD;   end
         SQ_LOW:   begin tmr_load = tmr_zero; tmr_val = HI_LD;   end
         SQ_HIGH:  begin
            tmr_load = tmr_zero;
            tmr_val  = (bit_idx == '0) ? TAIL_LD : LO_LD;
         end
         SQ_TAIL:  begin tmr_load = tmr_zero; tmr_val = LEW_LD;  end
         SQ_LATCH: begin tmr_load = tmr_zero; tmr_val = GAP_LD;  end
         SQ_GAP:   begin tmr_load = tmr_zero; tmr_val = LO_LD;   end
         default:  begin tmr_load = 1'b0;     tmr_val = LO_LD;   end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         step     <= '0;
         bit_idx  <= '0;
         ser_clk  <= 1'b0;
         ser_data <= 1'b0;
         ser_le   <= 1'b0;
         busy     <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            SQ_IDLE: begin
               if (start) begin
                  busy     <= 1'b1;
                  bit_idx  <= TOP_BIT;
                  ser_data <= cur_word[WORD_W-1];
                  state    <= SQ_LOW;
               end
            end
            SQ_LOW: begin
               if (tmr_zero) begin
                  ser_clk <= 1'b1;
                  state   <= SQ_HIGH;
               end
            end
            SQ_HIGH: begin
               if (tmr_zero) begin
                  ser_clk <= 1'b0;
                  if (bit_idx == '0) begin
                     state <= SQ_TAIL;
                  end else begin
                     bit_idx  <= bit_idx - 1'b1;
                     ser_data <= cur_word[bit_idx - 1'b1];
                     state    <= SQ_LOW;
                  end
               end
            end
            SQ_TAIL: begin
               if (tmr_zero) begin
                  ser_le <= 1'b1;
                  state  <= SQ_LATCH;
               end
            end
            SQ_LATCH: begin
               if (tmr_zero) begin
                  ser_le <= 1'b0;
                  step   <= step + 1'b1;
                  if (step == LAST_STEP) begin
                     busy  <= 1'b0;
                     done  <= 1'b1;
                     state <= SQ_IDLE;
                  end else begin
                     state <= SQ_GAP;
                  end
               end
            end
            SQ_GAP: begin
               if (tmr_zero) begin
                  bit_idx  <= TOP_BIT;
                  ser_data <= cur_word[WORD_W-1];
                  state    <= SQ_LOW;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cfgseq_chk.sv
module cfgseq_chk #(
   parameter int LO_CYC  = 3,
   parameter int HI_CYC  = 3,
   parameter int LEW_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic ser_clk,
   input logic ser_data,
   input logic ser_le,
   input logic busy,
   input logic done
);

   logic [15:0] lo_cnt, hi_cnt, le_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt <= '0;
         hi_cnt <= '0;
         le_cnt <= '0;
      end else begin
         lo_cnt <= ser_clk ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
         hi_cnt <= !ser_clk ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
         le_cnt <= !ser_le ? '0 : ((le_cnt == '1) ? le_cnt : le_cnt + 1'b1);
      end
   end

   assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data));

   assert_clk_high_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> (hi_cnt >= 16'(HI_CYC)));

   assert_clk_low_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_clk) |-> (lo_cnt >= 16'(LO_CYC)));

   assert_le_clk_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_le && ser_clk));

   assert_le_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_le) |-> (le_cnt >= 16'(LEW_CYC)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ser_clk && !ser_le));

endmodule

bind cfg_seq_master cfgseq_chk #(
   .LO_CYC  (LO_CYC),
   .HI_CYC  (HI_CYC),
   .LEW_CYC (LEW_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ser_clk  (ser_clk),
   .ser_data (ser_data),
   .ser_le   (ser_le),
   .busy     (busy),
   .done     (done)
);

// File: tb/cfg_seq_master_tb.sv
`timescale 1ns/1ps
module cfg_seq_master_tb;

   localparam int CLK_PERIOD = 10;
   localparam int EXP_HI  = 3;   // ceil(25/10)
   localparam int EXP_LO  = 3;   // ceil(25/10)
   localparam int EXP_LEW = 2;   // ceil(20/10)
   localparam int EXP_GAP = 2;   // ceil(20/10)
   localparam int WATCHDOG = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ser_clk, ser_data, ser_le, busy, done;

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   bit finished = 0;

   logic [31:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_seq_master #(.SYS_PERIOD_NS(CLK_PERIOD)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_le   (ser_le),
      .busy     (busy),
      .done     (done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   // monitor state
   logic        p_clk = 0, p_le = 0, p_data = 0, p_done = 0;
   int          run = 0;
   int          le_run = 0;
   int          le_low = 0;
   int          nbits = 0;
   int          min_hi = 1000, min_lo = 1000;
   bit          data_moved = 0;
   bit          le_seen = 0;
   int          les_in_run = 0;
   logic [31:0] shreg = '0;

   always @(negedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         check(0, "WDOG", "watchdog expired", cyc, WATCHDOG);
         wrap_up();
      end
      if (rst_n) begin
         if (ser_clk && ser_data !== p_data) data_moved = 1;
         if (ser_clk && ser_le)
            check(0, "R6", "strobe overlaps clock", 1, 0);
         if (ser_clk && !p_clk) begin
            if (run < min_lo) min_lo = run;
            if (nbits == 0 && le_seen)
               check(le_low >= EXP_GAP, "R7", "strobe-to-clock gap", le_low, EXP_GAP);
            shreg = {shreg[30:0], ser_data};
            nbits++;
            run = 1;
         end else if (!ser_clk && p_clk) begin
            if (run < min_hi) min_hi = run;
            run = 1;
         end else begin
            run++;
         end
         if (ser_le && !p_le) begin
            check(!p_clk, "R6", "strobe after clock fall", p_clk, 0);
            check(nbits == 32, "R3", "bits per word", nbits, 32);
            check(exp_q.size() > 0, "R2", "word expected", exp_q.size(), 1);
            if (exp_q.size() > 0) begin
               logic [31:0] e;
               e = exp_q.pop_front();
               check(shreg == e, "R2", "word value", shreg, e);
            end
            check(min_hi >= EXP_HI, "R5", "min clock high", min_hi, EXP_HI);
            check(min_lo >= EXP_LO, "R5", "min clock low", min_lo, EXP_LO);
            check(!data_moved, "R4", "data moved while clock high", data_moved, 0);
            nbits = 0; min_hi = 1000; min_lo = 1000; data_moved = 0;
            les_in_run++;
            le_seen = 1;
            le_run = 1;
         end else if (ser_le) begin
            le_run++;
         end
         if (!ser_le && p_le) begin
            check(le_run >= EXP_LEW, "R6", "strobe width", le_run, EXP_LEW);
            le_low = 1;
         end else if (!ser_le) begin
            le_low++;
         end
         if (done) begin
            check(!p_done, "R9", "done single cycle", p_done, 0);
            check(les_in_run == 8, "R9", "strobes before done", les_in_run, 8);
            check(!busy, "R9", "busy low with done", busy, 0);
            check(exp_q.size() == 0, "R2", "words left at done", exp_q.size(), 0);
            les_in_run = 0;
            le_seen = 0;
         end
      end
      p_clk = ser_clk; p_le = ser_le; p_data = ser_data; p_done = done;
   end

   task automatic push_table();
      exp_q.push_back(32'h0000_0003);
      exp_q.push_back(32'h0002_0406);
      exp_q.push_back(32'h2000_1499);
      exp_q.push_back(32'h4000_1499);
      exp_q.push_back(32'h6000_1499);
      exp_q.push_back(32'h8000_1499);
      exp_q.push_back(32'hA000_0019);
      exp_q.push_back(32'h8000_7CA0);
   endtask

   task automatic run_seq(input int extra_start_at);
      push_table();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R10", "busy after start", busy, 1);
      for (int i = 0; i < 20000 && !done; i++) begin
         if (extra_start_at > 0 && i == extra_start_at) begin
            start = 1'b1;   // R8: must be ignored
            @(negedge clk);
            start = 1'b0;
         end else begin
            @(negedge clk);
         end
      end
      check(done === 1'b1, "R9", "done reached", done, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({ser_clk, ser_data, ser_le, busy, done} == 5'b0, "R1", "outputs in reset",
            {ser_clk, ser_data, ser_le, busy, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({ser_clk, ser_data, ser_le, busy, done} == 5'b0, "R1", "outputs after reset",
            {ser_clk, ser_data, ser_le, busy, done}, 0);

      run_seq(700);   // R8: second start in the middle of the run

      repeat (400) @(negedge clk);
      check(les_in_run == 0, "R8", "no strobe after done", les_in_run, 0);
      check(!busy && !ser_clk && !ser_le, "R8", "idle after done",
            {busy, ser_clk, ser_le}, 0);

      run_seq(0);     // R11: rerun from the first word
      repeat (50) @(negedge clk);
      check(exp_q.size() == 0, "R11", "second run consumed table", exp_q.size(), 0);
      check(!busy, "R11", "idle after second run", busy, 0);
      wrap_up();
   end

endmodule